// File: doc/BRIEF.md
# Serial flash command engine

This block sits on a simple register bus and runs one serial flash transaction for each write to its command register. Software first loads an address register and a data register. It then writes a command word that gives the opcode, the direction, the number of data bytes, the number of address bytes, the number of dummy bytes, which chip-select line to use, and whether chip select stays asserted afterwards. The engine then sends an opcode byte, the address bytes, the dummy bytes and the data bytes in that order. It captures read data into the data register and reports progress and misuse through a status register.

Each command moves at most four data bytes. A keep-selected flag leaves chip select asserted when a command completes. The next command then continues the same flash transaction without resending the opcode, so software can chain commands into a transfer of any length. A final command that carries no data and has the flag clear releases the chip select line. The serial clock period comes from an external strobe `tick`, and each serial bit takes two strobes.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset all `cs_n` lines and `sck` are high, the status register reads zero, and the I/O control register reads 0xC with `wp_n` and `hold_n` high.
- R2: Register word offsets on `bus_addr` are: command 0, address 1, data 2, status 3, I/O control 4. The command word fields are: opcode in bits 7:0, write flag in bit 8 (1 = write), data byte count in bits 11:9 (values above 4 act as 4), keep flag in bit 15, dummy count in bits 19:16, address byte count in bits 22:20 (values above 3 act as 3), and chip-select index in bits 26:24.
- R3: A command that starts a new selection sends the opcode byte first. It then sends the low N bytes of the 24-bit address register, where N is the address byte count, with the most significant of those bytes first.
- R4: After the address, the engine sends the programmed number of dummy bytes (0 to 15), each 0x00.
- R5: Bytes are shifted most significant bit first in SPI mode 3: `sck` idles high, `mosi` changes only when `sck` falls, and `miso` is sampled when `sck` rises. Write data byte k is taken from data register bits 8k+7:8k.
- R6: A read command clears the data register when it is accepted. Received byte k is stored in bits 8k+7:8k, and `mosi` carries zeros during read data bytes.
- R7: Status bit 22 (pending) reads 1 from the cycle after a command is accepted until the last byte of that command has been captured.
- R8: A command write while pending is set sets status bit 29 (error). That write has no other effect.
- R9: Writing 1 to status bit 29 clears the error bit. Writing 0 to it leaves the bit unchanged.
- R10: With the keep flag set, chip select stays low after the command completes. The next command then skips the opcode and keeps the same chip-select line. A command with the keep flag clear releases chip select at its end.
- R11: While a line is held, a command with zero address, dummy and data counts and the keep flag clear releases chip select without any serial clock edges.
- R12: The chip-select index drives `cs_n[index]` low, and at most one `cs_n` line is ever low.
- R13: Bit 2 of the I/O control register drives `wp_n`, and bit 3 drives `hold_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| tick | input | 1 | Serial half-bit strobe from the timing block |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| cs_n | output | NUM_CS | Active-low chip selects |
| wp_n | output | 1 | Write-protect line, held high by default |
| hold_n | output | 1 | Hold line, held high by default |

## Verification
The bench runs the command path with several phase mixes: opcode with three address bytes and four write bytes; two address bytes, two dummy bytes and a three-byte read on a non-zero chip select; opcode plus dummy bytes only; and a one-byte-address write with an oversized data count. These cases separate byte ordering, lane placement and the count limits from one another. A chained read sequence shows whether the opcode is skipped, whether selection is held across commands, and whether the release-only command produces any clock edges. A command written while pending shows whether the busy write is rejected and whether the error clears only on a written 1.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   // command word field positions
   localparam int CMD_OPC_LSB  = 0;
   localparam int CMD_WR_BIT   = 8;
   localparam int CMD_CNT_LSB  = 9;
   localparam int CMD_KEEP_BIT = 15;
   localparam int CMD_DUM_LSB  = 16;
   localparam int CMD_ALEN_LSB = 20;
   localparam int CMD_CS_LSB   = 24;

   // status bit positions
   localparam int STAT_PEND_BIT = 22;
   localparam int STAT_ERR_BIT  = 29;

   // register word offsets
   localparam logic [2:0] REG_CMD  = 3'd0;
   localparam logic [2:0] REG_ADDR = 3'd1;
   localparam logic [2:0] REG_DATA = 3'd2;
   localparam logic [2:0] REG_STAT = 3'd3;
   localparam logic [2:0] REG_IO   = 3'd4;

   typedef struct packed {
      logic [7:0] opc;
      logic       wr;
      logic [2:0] cnt;
      logic       keep;
      logic [3:0] dum;
      logic [2:0] alen;
      logic [2:0] cs;
   } sfe_cmd_t;

   typedef enum logic [2:0] {
      PH_IDLE, PH_OPC, PH_ADR, PH_DUM, PH_DAT, PH_FIN
   } sfe_phase_e;

   function automatic sfe_cmd_t sfe_decode(input logic [31:0] w);
      sfe_cmd_t c;
      c.opc  = w[CMD_OPC_LSB +: 8];
      c.wr   = w[CMD_WR_BIT];
      c.cnt  = w[CMD_CNT_LSB +: 3];
      c.keep = w[CMD_KEEP_BIT];
      c.dum  = w[CMD_DUM_LSB +: 4];
      c.alen = w[CMD_ALEN_LSB +: 3];
      c.cs   = w[CMD_CS_LSB +: 3];
      return c;
   endfunction
endpackage

// File: rtl/sfe_shift.sv
module sfe_shift #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            start,
   input  logic [BITS-1:0] tx,
   input  logic            miso,
   output logic            busy,
   output logic            done,
   output logic [BITS-1:0] rx,
   output logic            sck_o,
   output logic            mosi_o
);
   localparam int CW = $clog2(BITS + 1);

   logic [BITS-1:0] sh_q;
   logic [CW-1:0]   left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
         sck_o  <= 1'b1;
         mosi_o <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            sh_q   <= tx;
            left_q <= CW'(BITS);
            busy   <= 1'b1;
         end else if (busy && tick) begin
            if (sck_o) begin
               sck_o  <= 1'b0;
               mosi_o <= sh_q[BITS-1];
            end else begin
               sck_o  <= 1'b1;
               sh_q   <= {sh_q[BITS-2:0], miso};
               left_q <= left_q - 1'b1;
               if (left_q == CW'(1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end
      end
   end

   assign rx = sh_q;

   // R5: data line moves only together with a falling clock
   a_r5_mosi_moves_on_fall : assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(sck_o) |-> $stable(mosi_o));
   // R5: clock rests high whenever no byte is in flight
   a_r5_idle_clock_high : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_o);
endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
   import sfe_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   parameter int DATA_BYTES = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          go_i,
   input  sfe_cmd_t                      cmd_i,
   input  logic [8*ADDR_BYTES-1:0]       addr_i,
   input  logic [8*DATA_BYTES-1:0]       wdata_i,
   input  logic                          busy_i,
   input  logic                          done_i,
   input  logic [7:0]                    rx_i,
   output logic                          start_o,
   output logic [7:0]                    tx_o,
   output logic                          pend_o,
   output logic                          held_o,
   output logic [2:0]                    csel_o,
   output logic                          rd_we_o,
   output logic [$clog2(DATA_BYTES)-1:0] rd_lane_o,
   output logic [7:0]                    rd_byte_o
);
   localparam int AW = 8 * ADDR_BYTES;
   localparam int DW = 8 * DATA_BYTES;
   localparam int LW = $clog2(DATA_BYTES);

   function automatic logic [3:0] eff_alen(input sfe_cmd_t c);
      int a = int'(c.alen);
      if (a > ADDR_BYTES) a = ADDR_BYTES;
      return 4'(a);
   endfunction

   function automatic logic [3:0] eff_cnt(input sfe_cmd_t c);
      int n = int'(c.cnt);
      if (n > DATA_BYTES) n = DATA_BYTES;
      return 4'(n);
   endfunction

   function automatic sfe_phase_e after(input sfe_phase_e p, input sfe_cmd_t c);
      if ((p == PH_IDLE || p == PH_OPC) && eff_alen(c) != 4'd0) return PH_ADR;
      if (p != PH_DUM && p != PH_DAT && c.dum != 4'd0) return PH_DUM;
      if (p != PH_DAT && eff_cnt(c) != 4'd0) return PH_DAT;
      return PH_FIN;
   endfunction

   function automatic logic [3:0] span(input sfe_phase_e p, input sfe_cmd_t c);
      case (p)
         PH_OPC:  return 4'd1;
         PH_ADR:  return eff_alen(c);
         PH_DUM:  return c.dum;
         PH_DAT:  return eff_cnt(c);
         default: return 4'd0;
      endcase
   endfunction

   sfe_cmd_t      c_q;
   sfe_phase_e    ph_q, go_ph, nx_ph;
   logic [3:0]    cnt_q;
   logic [LW-1:0] lane_q;
   logic          fly_q, held_q, pend_q;
   logic [2:0]    csel_q;
   logic          in_byte;
   logic [AW-1:0] a_sh;
   logic [DW-1:0] d_sh;

   always_comb begin
      go_ph   = held_q ? after(PH_OPC, cmd_i) : PH_OPC;
      nx_ph   = after(ph_q, c_q);
      in_byte = ph_q inside {PH_OPC, PH_ADR, PH_DUM, PH_DAT};
      start_o = in_byte && !fly_q && !busy_i;
      a_sh    = addr_i >> {cnt_q - 4'd1, 3'b000};
      d_sh    = wdata_i >> {lane_q, 3'b000};
      case (ph_q)
         PH_OPC:  tx_o = c_q.opc;
         PH_ADR:  tx_o = a_sh[7:0];
         PH_DAT:  tx_o = c_q.wr ? d_sh[7:0] : 8'h00;
         default: tx_o = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q    <= '0;
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         lane_q <= '0;
         fly_q  <= 1'b0;
         held_q <= 1'b0;
         pend_q <= 1'b0;
         csel_q <= '0;
      end else if (go_i) begin
         c_q    <= cmd_i;
         pend_q <= 1'b1;
         lane_q <= '0;
         fly_q  <= 1'b0;
         ph_q   <= go_ph;
         cnt_q  <= span(go_ph, cmd_i);
         if (!held_q) begin
            held_q <= 1'b1;
            csel_q <= cmd_i.cs;
         end
      end else if (ph_q == PH_FIN) begin
         ph_q   <= PH_IDLE;
         pend_q <= 1'b0;
         if (!c_q.keep) held_q <= 1'b0;
      end else if (in_byte) begin
         if (start_o) fly_q <= 1'b1;
         if (done_i) begin
            fly_q <= 1'b0;
            if (ph_q == PH_DAT) lane_q <= lane_q + 1'b1;
            if (cnt_q == 4'd1) begin
               ph_q  <= nx_ph;
               cnt_q <= span(nx_ph, c_q);
            end else begin
               cnt_q <= cnt_q - 4'd1;
            end
         end
      end
   end

   assign pend_o    = pend_q;
   assign held_o    = held_q;
   assign csel_o    = csel_q;
   assign rd_we_o   = done_i && ph_q == PH_DAT && !c_q.wr;
   assign rd_lane_o = lane_q;
   assign rd_byte_o = rx_i;

   // R7: pending drops only once the shifter has finished its last byte
   a_r7_pending_ends_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q) |-> (!busy_i && !fly_q));
   // R10: a command continuing a held selection never enters the opcode phase
   a_r10_held_skips_opcode : assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && held_q) |=> ph_q != PH_OPC);
   // R6: captured bytes land only while the command is pending
   a_r6_capture_in_command : assert property (@(posedge clk) disable iff (!rst_n)
      rd_we_o |-> pend_q);
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
   import sfe_pkg::*;
#(
   parameter int NUM_CS     = 8,
   parameter int ADDR_BYTES = 3,
   parameter int DATA_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              tick,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_n,
   output logic              wp_n,
   output logic              hold_n
);
   localparam int AW = 8 * ADDR_BYTES;
   localparam int DB = DATA_W / 8;
   localparam int LW = $clog2(DB);

   if (NUM_CS < 1 || NUM_CS > 8) begin : g_bad_cs
      $error("NUM_CS must lie in 1..8");
   end
   if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_addr
      $error("ADDR_BYTES must lie in 1..4");
   end
   if (DATA_W % 8 != 0 || DB < 2 || DB > 4) begin : g_bad_data
      $error("DATA_W must be 16, 24 or 32");
   end

   sfe_cmd_t      cmd;
   logic          go, pend, held;
   logic [2:0]    csel;
   logic [AW-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic          err_q;
   logic [3:0]    io_q;
   logic          sh_start, sh_busy, sh_done;
   logic [7:0]    sh_tx, sh_rx, rd_byte;
   logic          rd_we;
   logic [LW-1:0] rd_lane;

   assign cmd = sfe_decode(bus_wdata);
   assign go  = bus_wr && bus_addr == REG_CMD && !pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         err_q  <= 1'b0;
         io_q   <= 4'b1100;
      end else begin
         if (bus_wr) begin
            case (bus_addr)
               REG_ADDR: addr_q <= bus_wdata[AW-1:0];
               REG_DATA: data_q <= bus_wdata[DATA_W-1:0];
               REG_IO:   io_q   <= bus_wdata[3:0];
               REG_STAT: if (bus_wdata[STAT_ERR_BIT]) err_q <= 1'b0;
               REG_CMD: begin
                  if (pend)         err_q  <= 1'b1;
                  else if (!cmd.wr) data_q <= '0;
               end
               default: ;
            endcase
         end
         if (rd_we) data_q[{rd_lane, 3'b000} +: 8] <= rd_byte;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_ADDR: bus_rdata = 32'(addr_q);
         REG_DATA: bus_rdata = 32'(data_q);
         REG_STAT: begin
            bus_rdata[STAT_PEND_BIT] = pend;
            bus_rdata[STAT_ERR_BIT]  = err_q;
         end
         REG_IO:   bus_rdata = {28'd0, io_q};
         default:  bus_rdata = '0;
      endcase
   end

   sfe_seq #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DB)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (go),
      .cmd_i    (cmd),
      .addr_i   (addr_q),
      .wdata_i  (data_q),
      .busy_i   (sh_busy),
      .done_i   (sh_done),
      .rx_i     (sh_rx),
      .start_o  (sh_start),
      .tx_o     (sh_tx),
      .pend_o   (pend),
      .held_o   (held),
      .csel_o   (csel),
      .rd_we_o  (rd_we),
      .rd_lane_o(rd_lane),
      .rd_byte_o(rd_byte)
   );

   sfe_shift #(.BITS(8)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .start (sh_start),
      .tx    (sh_tx),
      .miso  (miso),
      .busy  (sh_busy),
      .done  (sh_done),
      .rx    (sh_rx),
      .sck_o (sck),
      .mosi_o(mosi)
   );

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_n[i] = !(held && csel == 3'(i));
   end

   assign wp_n   = io_q[2];
   assign hold_n = io_q[3];

   // R12: never more than one flash selected
   a_r12_single_select : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   // R1: with every line deselected the serial clock rests high
   a_r1_deselected_clock_high : assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> sck);
   // R8: a command write during a pending command leaves the error bit set
   a_r8_busy_write_flags : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_CMD && pend) |=> (err_q && pend));
endmodule

// File: tb/sflash_cmd_engine_tb.sv
module sflash_cmd_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] A_CMD = 3'd0, A_ADDR = 3'd1, A_DATA = 3'd2, A_STAT = 3'd3, A_IO = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        tick = 1'b1;
   logic        sck, mosi;
   logic        miso = 1'b0;
   logic [7:0]  cs_n;
   logic        wp_n, hold_n;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sflash_cmd_engine u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .sck(sck),
      .mosi(mosi), .miso(miso), .cs_n(cs_n), .wp_n(wp_n), .hold_n(hold_n)
   );

   // flash model: logs every byte seen, returns a position-derived pattern
   logic       cs_idle;
   logic [7:0] log_b [0:255];
   int         log_n = 0;
   int         pos = 0;
   int         bitn = 0;
   logic [7:0] sr = 8'd0;
   assign cs_idle = &cs_n;

   function automatic logic [7:0] pat(input int p);
      return 8'h3C ^ 8'(p * 37);
   endfunction

   always @(posedge sck or posedge cs_idle) begin
      if (cs_idle !== 1'b0) begin
         pos  = 0;
         bitn = 0;
      end else begin
         sr = {sr[6:0], mosi};
         bitn++;
         if (bitn == 8) begin
            log_b[log_n % 256] = sr;
            log_n++;
            bitn = 0;
            pos++;
         end
      end
   end

   always @(negedge sck) begin
      logic [7:0] t;
      if (cs_idle === 1'b0) begin
         t = pat(pos);
         miso <= t[7 - bitn];
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] mkcmd(input logic [7:0] opc, input logic wr, input logic [2:0] cnt,
                                         input logic keep, input logic [3:0] dum, input logic [2:0] alen,
                                         input logic [2:0] cs);
      return {5'd0, cs, 1'b0, alen, dum, keep, 3'd0, cnt, wr, opc};
   endfunction

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         reg_read(A_STAT, s);
         if (!s[22]) return;
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1", "cs_n", 32'(cs_n), 32'hFF);
      chk("R1", "sck", 32'(sck), 32'd1);
      reg_read(A_STAT, d);  chk("R1", "status", d, 32'd0);
      reg_read(A_IO, d);    chk("R1", "io readback", d, 32'hC);
      chk("R1", "wp_n/hold_n", 32'({hold_n, wp_n}), 32'd3);
   endtask

   task automatic t_write_full();
      logic [31:0] d;
      logic [7:0] exp [8] = '{8'h02, 8'h12, 8'h34, 8'h56, 8'hAA, 8'hBB, 8'hCC, 8'hDD};
      int base = log_n;
      reg_write(A_ADDR, 32'h00123456);
      reg_write(A_DATA, 32'hDDCCBBAA);
      reg_write(A_CMD, mkcmd(8'h02, 1'b1, 3'd4, 1'b0, 4'd0, 3'd3, 3'd0));
      reg_read(A_STAT, d);
      chk("R7", "pending after issue", 32'(d[22]), 32'd1);
      chk("R12", "cs line 0 low", 32'(cs_n), 32'hFE);
      wait_idle();
      chk("R3", "byte count", 32'(log_n - base), 32'd8);
      for (int i = 0; i < 8; i++)
         chk(i < 4 ? "R3" : "R5", $sformatf("write byte %0d", i), 32'(log_b[(base + i) % 256]), 32'(exp[i]));
      chk("R10", "released after keep clear", 32'(cs_n), 32'hFF);
      chk("R5", "clock idle high", 32'(sck), 32'd1);
   endtask

   task automatic t_read_dummy();
      logic [31:0] d;
      int base;
      reg_write(A_DATA, 32'hFFFFFFFF);
      reg_write(A_ADDR, 32'h0000ABCD);
      base = log_n;
      reg_write(A_CMD, mkcmd(8'h0B, 1'b0, 3'd3, 1'b0, 4'd2, 3'd2, 3'd2));
      chk("R12", "cs line 2 low", 32'(cs_n), 32'hFB);
      wait_idle();
      chk("R3", "byte count", 32'(log_n - base), 32'd8);
      chk("R3", "opcode", 32'(log_b[base % 256]), 32'h0B);
      chk("R3", "addr hi", 32'(log_b[(base + 1) % 256]), 32'hAB);
      chk("R3", "addr lo", 32'(log_b[(base + 2) % 256]), 32'hCD);
      chk("R4", "dummy 0", 32'(log_b[(base + 3) % 256]), 32'h00);
      chk("R4", "dummy 1", 32'(log_b[(base + 4) % 256]), 32'h00);
      chk("R6", "mosi zero in read", 32'(log_b[(base + 5) % 256]), 32'h00);
      reg_read(A_DATA, d);
      chk("R6", "read lanes", d, {8'h00, pat(7), pat(6), pat(5)});
   endtask

   task automatic t_busy_error();
      logic [31:0] d;
      int base = log_n;
      reg_write(A_CMD, mkcmd(8'h9F, 1'b0, 3'd0, 1'b0, 4'd3, 3'd0, 3'd0));
      reg_write(A_CMD, mkcmd(8'h77, 1'b1, 3'd4, 1'b1, 4'd0, 3'd3, 3'd1));
      reg_read(A_STAT, d);
      chk("R8", "error on busy write", 32'(d[29]), 32'd1);
      wait_idle();
      chk("R8", "second command ignored, bytes", 32'(log_n - base), 32'd4);
      chk("R8", "first opcode kept", 32'(log_b[base % 256]), 32'h9F);
      for (int i = 1; i < 4; i++)
         chk("R4", $sformatf("dummy byte %0d", i), 32'(log_b[(base + i) % 256]), 32'h00);
      chk("R8", "no held select", 32'(cs_n), 32'hFF);
      reg_write(A_STAT, 32'd0);
      reg_read(A_STAT, d);
      chk("R9", "write 0 keeps error", 32'(d[29]), 32'd1);
      reg_write(A_STAT, 32'h20000000);
      reg_read(A_STAT, d);
      chk("R9", "write 1 clears error", d, 32'd0);
   endtask

   task automatic t_chain();
      logic [31:0] d;
      int base;
      reg_write(A_ADDR, 32'h00000010);
      base = log_n;
      reg_write(A_CMD, mkcmd(8'h03, 1'b0, 3'd4, 1'b1, 4'd0, 3'd3, 3'd0));
      wait_idle();
      chk("R10", "held after keep", 32'(cs_n), 32'hFE);
      chk("R3", "first segment bytes", 32'(log_n - base), 32'd8);
      reg_read(A_DATA, d);
      chk("R6", "first read word", d, {pat(7), pat(6), pat(5), pat(4)});
      base = log_n;
      reg_write(A_CMD, mkcmd(8'hAA, 1'b0, 3'd2, 1'b1, 4'd0, 3'd0, 3'd3));
      wait_idle();
      chk("R10", "opcode skipped", 32'(log_n - base), 32'd2);
      chk("R10", "same line held", 32'(cs_n), 32'hFE);
      reg_read(A_DATA, d);
      chk("R6", "continued read, upper cleared", d, {16'h0000, pat(9), pat(8)});
      base = log_n;
      reg_write(A_CMD, mkcmd(8'h55, 1'b0, 3'd0, 1'b0, 4'd0, 3'd0, 3'd0));
      wait_idle();
      chk("R11", "no clocks on release", 32'(log_n - base), 32'd0);
      chk("R11", "released", 32'(cs_n), 32'hFF);
   endtask

   task automatic t_clamp();
      int base;
      reg_write(A_ADDR, 32'h00123456);
      reg_write(A_DATA, 32'h11223344);
      base = log_n;
      reg_write(A_CMD, mkcmd(8'h06, 1'b1, 3'd7, 1'b0, 4'd0, 3'd1, 3'd5));
      chk("R12", "cs line 5 low", 32'(cs_n), 32'hDF);
      wait_idle();
      chk("R2", "count above 4 acts as 4", 32'(log_n - base), 32'd6);
      chk("R3", "one address byte is the low one", 32'(log_b[(base + 1) % 256]), 32'h56);
      chk("R5", "lane 0 first", 32'(log_b[(base + 2) % 256]), 32'h44);
      chk("R5", "lane 3 last", 32'(log_b[(base + 5) % 256]), 32'h11);
   endtask

   task automatic t_io();
      logic [31:0] d;
      reg_write(A_IO, 32'h0);
      chk("R13", "wp_n/hold_n low", 32'({hold_n, wp_n}), 32'd0);
      reg_write(A_IO, 32'h8);
      chk("R13", "hold_n only", 32'({hold_n, wp_n}), 32'd2);
      reg_read(A_IO, d);
      chk("R13", "io readback", d, 32'h8);
      reg_write(A_IO, 32'hC);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_write_full();
      t_read_dummy();
      t_busy_error();
      t_chain();
      t_clamp();
      t_io();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule